// File: doc/BRIEF.md
# Protection-Bit Program/Erase Sequencer

This block sits on the host side of a parallel flash bus and runs the six-cycle sequence that sets or clears one non-volatile protection bit of a sector. The caller gives a one-cycle start request with the operation (set or clear) and a sector number. The sequencer then drives each bus cycle through a request/acknowledge handshake. It enforces the settling time the flash needs after the operation command, reads back the bit, and decides whether the attempt worked.

When the read-back shows the bit has not reached its target value, the sequencer starts the whole six-cycle sequence again from the first unlock write. It does not repeat only the last two cycles. After a parameterised number of attempts it gives up and reports failure. A clear (erase) operation is only accepted when the caller confirms that the bits were all set beforehand. Without that confirmation the request is refused and the bus stays idle. The settling times are given in microseconds and turned into clock counts from a clock-frequency parameter.

Top module: `pbit_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `bus_req`, `busy`, `done`, `fail` and `rej` are all 0.
- R2: Each attempt opens with three writes: data AAh to unlock address A, then 55h to unlock address B, then 60h to unlock address A. With `WORD_ADDR`=1, A is 555h and B is 2AAh. With `WORD_ADDR`=0, A is AAAh and B is 555h. Command data sits in bits 7:0 and all higher data bits are 0.
- R3: The fourth cycle writes 68h for a set or 60h for a clear. Its target address is {sector, zeros, low7}. The sector is in the top `SECT_W` bits, and low7 is 0111010b for a set or 1111010b for a clear.
- R4: The fifth cycle writes 48h for a set or 40h for a clear, to the same address as the fourth cycle. The sixth cycle is a read (`bus_we`=0) from {sector, zeros, 0111010b} for both operations.
- R5: After the fourth cycle is acknowledged, `bus_req` stays low before the fifth cycle for at least N clock cycles and at most N+1. N is `CLK_MHZ`*`PROG_WAIT_US` for a set and `CLK_MHZ`*`ERASE_WAIT_US` for a clear.
- R6: Only read-data bit 0 decides the result. A set passes when it is 1 and a clear passes when it is 0. A pass raises `done` for one cycle and returns the block to idle.
- R7: A failed read-back with attempts remaining restarts the sequence from the first unlock write of R2.
- R8: When the `MAX_TRIES`-th attempt fails, `fail` is raised for one cycle. No further bus cycles follow.
- R9: A clear request with `req_preprog`=0 raises `rej` for one cycle and issues no bus cycle.
- R10: While `busy` is 1, `req_valid` is ignored. The running sequence and its result are unchanged.
- R11: While `bus_req` is 1 and `bus_ack` is 0, `bus_addr`, `bus_wdata` and `bus_we` hold their values.
- R12: At most one of `done`, `fail` and `rej` is high in a cycle, and each stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle start request |
| req_erase | input | 1 | 1 = clear the bit, 0 = set the bit |
| req_sector | input | SECT_W | Target sector number |
| req_preprog | input | 1 | Caller confirms all bits were set (required for a clear) |
| busy | output | 1 | A sequence is running |
| bus_req | output | 1 | Bus cycle requested |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | One-cycle acknowledge; completes the current bus cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` on a read |
| done | output | 1 | One-cycle pulse: bit verified |
| fail | output | 1 | One-cycle pulse: attempts exhausted |
| rej | output | 1 | One-cycle pulse: clear refused |

## Verification
The bench targets the opposite pass polarity of set and clear, with upper read-data bits set to junk. A design that tested the wrong level, or the whole byte, would end a good clear with a failure or accept a bad set. It measures the idle gap after the operation command for both waits: a timer loaded one short, or always loaded with the set value, breaks the minimum on a clear. Retry runs check that the expected queue replays from the unlock writes each time and runs dry exactly at the attempt limit. A design that retried only the verify cycles, or stopped one attempt early or late, leaves the queue out of step. A refused clear and a request arriving mid-sequence must both leave the bus silent and produce no extra result pulse.

// File: rtl/pbit_pkg.sv
package pbit_pkg;

   // command bytes placed on data bits 7:0
   localparam logic [7:0] CMD_UNLOCK_A  = 8'hAA;
   localparam logic [7:0] CMD_UNLOCK_B  = 8'h55;
   localparam logic [7:0] CMD_SETUP     = 8'h60;
   localparam logic [7:0] CMD_PROG_OP   = 8'h68;
   localparam logic [7:0] CMD_ERASE_OP  = 8'h60;
   localparam logic [7:0] CMD_PROG_VFY  = 8'h48;
   localparam logic [7:0] CMD_ERASE_VFY = 8'h40;

   // low address field selecting the protection-bit operation
   localparam int         LOW_W     = 7;
   localparam logic [6:0] LOW_PROG  = 7'b0111010;
   localparam logic [6:0] LOW_ERASE = 7'b1111010;

   // step numbering inside one attempt
   localparam logic [2:0] STEP_FIRST = 3'd0;
   localparam logic [2:0] STEP_OP    = 3'd3;
   localparam logic [2:0] STEP_VFY   = 3'd4;
   localparam logic [2:0] STEP_READ  = 3'd5;

   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } pbit_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2
   } pbit_state_e;

endpackage

// File: rtl/pbit_step_decode.sv
module pbit_step_decode
   import pbit_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int SECT_W    = 10,
   parameter int DATA_W    = 16,
   parameter int WORD_ADDR = 1
) (
   input  logic [2:0]        step,
   input  pbit_op_e          op,
   input  logic [SECT_W-1:0] sector,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              we
);

   localparam int PAD_W = ADDR_W - SECT_W - LOW_W;

   logic [ADDR_W-1:0] unlk_a;
   logic [ADDR_W-1:0] unlk_b;
   logic [ADDR_W-1:0] tgt_op;
   logic [ADDR_W-1:0] tgt_read;
   logic [LOW_W-1:0]  op_low;
   logic [7:0]        cmd;

   // unlock address pair depends on the bus addressing granularity
   generate
      if (WORD_ADDR != 0) begin : g_word
         assign unlk_a = ADDR_W'(12'h555);
         assign unlk_b = ADDR_W'(12'h2AA);
      end else begin : g_byte
         assign unlk_a = ADDR_W'(12'hAAA);
         assign unlk_b = ADDR_W'(12'h555);
      end
   endgenerate

   assign op_low   = (op == OP_ERASE) ? LOW_ERASE : LOW_PROG;
   assign tgt_op   = {sector, {PAD_W{1'b0}}, op_low};
   assign tgt_read = {sector, {PAD_W{1'b0}}, LOW_PROG};

   always_comb begin
      unique case (step)
         3'd0:      begin addr = unlk_a;   cmd = CMD_UNLOCK_A; end
         3'd1:      begin addr = unlk_b;   cmd = CMD_UNLOCK_B; end
         3'd2:      begin addr = unlk_a;   cmd = CMD_SETUP;    end
         STEP_OP:   begin addr = tgt_op;
                          cmd  = (op == OP_ERASE) ? CMD_ERASE_OP : CMD_PROG_OP; end
         STEP_VFY:  begin addr = tgt_op;
                          cmd  = (op == OP_ERASE) ? CMD_ERASE_VFY : CMD_PROG_VFY; end
         STEP_READ: begin addr = tgt_read; cmd = 8'h00; end
         default:   begin addr = '0;       cmd = 8'h00; end
      endcase
   end

   assign wdata = DATA_W'(cmd);
   assign we    = (step != STEP_READ);

endmodule

// File: rtl/pbit_wait_timer.sv
module pbit_wait_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/pbit_retry_ctr.sv
module pbit_retry_ctr #(
   parameter int MAX_TRIES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic last
);

   localparam int TW = $clog2(MAX_TRIES + 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (bump) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign last = (cnt == TW'(MAX_TRIES - 1));

endmodule

// File: rtl/pbit_seq.sv
module pbit_seq
   import pbit_pkg::*;
#(
   parameter int ADDR_W        = 22,
   parameter int SECT_W        = 10,
   parameter int DATA_W        = 16,
   parameter int WORD_ADDR     = 1,
   parameter int CLK_MHZ       = 200,
   parameter int PROG_WAIT_US  = 100,
   parameter int ERASE_WAIT_US = 1200,
   parameter int MAX_TRIES     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_erase,
   input  logic [SECT_W-1:0] req_sector,
   input  logic              req_preprog,
   output logic              busy,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output logic              fail,
   output logic              rej
);

   localparam int PROG_CYC  = CLK_MHZ * PROG_WAIT_US;
   localparam int ERASE_CYC = CLK_MHZ * ERASE_WAIT_US;
   localparam int MAX_CYC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < SECT_W + 12) begin : g_bad_addr
         $error("pbit_seq: ADDR_W must leave 12 bits below the sector field");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("pbit_seq: DATA_W must hold an 8-bit command");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("pbit_seq: MAX_TRIES must be at least 1");
      end
      if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_wait
         $error("pbit_seq: wait times must be at least one clock");
      end
   endgenerate

   pbit_state_e       st;
   logic [2:0]        step;
   pbit_op_e          op_q;
   logic [SECT_W-1:0] sect_q;
   logic              bit_ok;
   logic              tmr_load;
   logic              tmr_expired;
   logic [CNT_W-1:0]  tmr_val;
   logic              try_clear;
   logic              try_bump;
   logic              try_last;
   logic              accept;
   logic              unused_rdata;

   assign unused_rdata = ^bus_rdata[DATA_W-1:1];

   // pass polarity differs between set and clear
   assign bit_ok   = (op_q == OP_ERASE) ? ~bus_rdata[0] : bus_rdata[0];
   assign accept   = (st == SQ_IDLE) && req_valid && !(req_erase && !req_preprog);
   assign tmr_load = (st == SQ_ISSUE) && bus_ack && (step == STEP_OP);
   assign tmr_val  = (op_q == OP_ERASE) ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
   assign try_clear = accept;
   assign try_bump  = (st == SQ_ISSUE) && bus_ack && (step == STEP_READ) && !bit_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         step   <= STEP_FIRST;
         op_q   <= OP_PROG;
         sect_q <= '0;
         done   <= 1'b0;
         fail   <= 1'b0;
         rej    <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         rej  <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (req_valid) begin
                  if (req_erase && !req_preprog) begin
                     rej <= 1'b1;
                  end else begin
                     op_q   <= req_erase ? OP_ERASE : OP_PROG;
                     sect_q <= req_sector;
                     step   <= STEP_FIRST;
                     st     <= SQ_ISSUE;
                  end
               end
            end
            SQ_ISSUE: begin
               if (bus_ack) begin
                  if (step == STEP_OP) begin
                     st <= SQ_WAIT;
                  end else if (step == STEP_READ) begin
                     if (bit_ok) begin
                        done <= 1'b1;
                        st   <= SQ_IDLE;
                     end else if (try_last) begin
                        fail <= 1'b1;
                        st   <= SQ_IDLE;
                     end else begin
                        step <= STEP_FIRST;
                     end
                  end else begin
                     step <= step + 3'd1;
                  end
               end
            end
            SQ_WAIT: begin
               if (tmr_expired) begin
                  step <= STEP_VFY;
                  st   <= SQ_ISSUE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   pbit_step_decode #(
      .ADDR_W   (ADDR_W),
      .SECT_W   (SECT_W),
      .DATA_W   (DATA_W),
      .WORD_ADDR(WORD_ADDR)
   ) u_dec (
      .step  (step),
      .op    (op_q),
      .sector(sect_q),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .we    (bus_we)
   );

   pbit_wait_timer #(
      .CNT_W(CNT_W)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (tmr_expired)
   );

   pbit_retry_ctr #(
      .MAX_TRIES(MAX_TRIES)
   ) u_try (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(try_clear),
      .bump (try_bump),
      .last (try_last)
   );

   assign bus_req = (st == SQ_ISSUE);
   assign busy    = (st != SQ_IDLE);

endmodule

// File: rtl/pbit_seq_chk.sv
module pbit_seq_chk
   import pbit_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int DATA_W    = 16,
   parameter int PROG_CYC  = 1,
   parameter int ERASE_CYC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack,
   input logic              done,
   input logic              fail,
   input logic              rej
);

   localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int GW   = $clog2(MAXC + 4) + 1;

   logic          armed;
   logic [GW-1:0] gap;
   logic [GW-1:0] need;
   logic          low_prog;
   logic          low_erase;
   logic          op_ack;

   assign low_prog  = (bus_addr[LOW_W-1:0] == LOW_PROG);
   assign low_erase = (bus_addr[LOW_W-1:0] == LOW_ERASE);
   assign op_ack    = bus_req && bus_ack && bus_we &&
                      ((low_prog && bus_wdata[7:0] == CMD_PROG_OP) ||
                       (low_erase && bus_wdata[7:0] == CMD_ERASE_OP));

   // measures the idle window after the operation command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         gap   <= '0;
         need  <= '0;
      end else if (op_ack) begin
         armed <= 1'b1;
         gap   <= GW'(1);
         need  <= low_erase ? GW'(ERASE_CYC) : GW'(PROG_CYC);
      end else if (armed) begin
         if (bus_req) armed <= 1'b0;
         else         gap   <= gap + 1'b1;
      end
   end

   AST_WAIT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && bus_req) |-> (gap > need));                              // R5

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                 $stable(bus_wdata) && $stable(bus_we))); // R11

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fail, rej}));                                      // R12

   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail || rej) |=> !(done || fail || rej));                 // R12

   AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> (!bus_req && !busy));                           // R8

   AST_REJ_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      rej |-> (!bus_req && !busy));                                      // R9

endmodule

bind pbit_seq pbit_seq_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .PROG_CYC (CLK_MHZ * PROG_WAIT_US),
   .ERASE_CYC(CLK_MHZ * ERASE_WAIT_US)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_ack  (bus_ack),
   .done     (done),
   .fail     (fail),
   .rej      (rej)
);

// File: tb/sim_pbit_seq.sv
module sim_pbit_seq;

   localparam int ADDR_W    = 22;
   localparam int SECT_W    = 10;
   localparam int DATA_W    = 16;
   localparam int CLK_MHZ   = 1;
   localparam int P_US      = 100;
   localparam int E_US      = 1200;
   localparam int TRIES     = 3;
   localparam int PCYC      = CLK_MHZ * P_US;
   localparam int ECYC      = CLK_MHZ * E_US;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_erase = 1'b0;
   logic [SECT_W-1:0] req_sector = '0;
   logic              req_preprog = 1'b0;
   logic              busy, bus_req, bus_we, done, fail, rej;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic              bus_ack = 1'b0;
   logic [DATA_W-1:0] bus_rdata = '0;

   int checks = 0;
   int fails  = 0;
   longint cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   pbit_seq #(
      .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W), .WORD_ADDR(1),
      .CLK_MHZ(CLK_MHZ), .PROG_WAIT_US(P_US), .ERASE_WAIT_US(E_US),
      .MAX_TRIES(TRIES)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
      .req_sector(req_sector), .req_preprog(req_preprog), .busy(busy),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .done(done), .fail(fail), .rej(rej)
   );

   typedef struct {
      logic [ADDR_W-1:0] a;
      logic              we;
      logic [DATA_W-1:0] d;
      bit                op_cyc;
      int                wait_n;
      string             rq;
   } tx_t;

   typedef struct {
      logic [2:0] r;   // {done, fail, rej}
      string      rq;
   } res_t;

   tx_t  exp_q[$];
   res_t res_q[$];

   // flash model state
   bit  m_erase = 1'b0;
   int  m_fails = 0;
   int  m_reads = 0;
   int  lat = 0;
   int  lat_need = 0;
   int  tx_cnt = 0;
   bit  gap_armed = 1'b0;
   longint op_cyc_at = 0;
   int  gap_need = 0;
   bit  prev_req = 1'b0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   function automatic tx_t mk(input logic [ADDR_W-1:0] a, input logic we,
                              input logic [7:0] d, input bit oc, input int w,
                              input string rq);
      tx_t t;
      t.a = a; t.we = we; t.d = DATA_W'(d); t.op_cyc = oc; t.wait_n = w; t.rq = rq;
      return t;
   endfunction

   function automatic logic [ADDR_W-1:0] tgt(input logic [SECT_W-1:0] s,
                                              input logic [6:0] low);
      return {s, 5'b00000, low};
   endfunction

   // driver side: expected bus cycles of one attempt (R2, R3, R4)
   task automatic push_attempt(input bit er, input logic [SECT_W-1:0] s);
      logic [6:0] low;
      low = er ? 7'b1111010 : 7'b0111010;
      exp_q.push_back(mk(22'h555, 1'b1, 8'hAA, 1'b0, 0, "R2"));
      exp_q.push_back(mk(22'h2AA, 1'b1, 8'h55, 1'b0, 0, "R2"));
      exp_q.push_back(mk(22'h555, 1'b1, 8'h60, 1'b0, 0, "R2"));
      exp_q.push_back(mk(tgt(s, low), 1'b1, er ? 8'h60 : 8'h68, 1'b1,
                         er ? ECYC : PCYC, "R3"));
      exp_q.push_back(mk(tgt(s, low), 1'b1, er ? 8'h40 : 8'h48, 1'b0, 0, "R4"));
      exp_q.push_back(mk(tgt(s, 7'b0111010), 1'b0, 8'h00, 1'b0, 0, "R4"));
   endtask

   // one negedge monitor: bus model, scoreboard pop, gap and result checks
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack = 1'b0;
         prev_req = 1'b0;
      end else begin
         if (gap_armed && bus_req && !prev_req) begin
            chk((cyc - op_cyc_at - 1) >= gap_need && (cyc - op_cyc_at - 1) <= gap_need + 1,
                "R5", "idle cycles before verify write", cyc - op_cyc_at - 1, gap_need);
            gap_armed = 1'b0;
         end
         prev_req = bus_req;

         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_req) begin
            if (lat < lat_need) begin
               lat++;
            end else begin
               tx_t e;
               lat = 0;
               tx_cnt++;
               lat_need = tx_cnt % 3;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R8", "unexpected bus cycle at address", bus_addr, 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(bus_addr == e.a, e.rq, "bus address", bus_addr, e.a);
                  chk(bus_we == e.we, e.rq, "bus direction", bus_we, e.we);
                  if (e.we)
                     chk(bus_wdata == e.d, e.rq, "bus write data", bus_wdata, e.d);
                  if (e.op_cyc) begin
                     gap_armed = 1'b1;
                     op_cyc_at = cyc;
                     gap_need  = e.wait_n;
                  end
               end
               if (!bus_we) begin
                  bit pass;
                  pass = (m_reads >= m_fails);
                  m_reads++;
                  // junk in upper bits; only bit 0 carries the state (R6)
                  if (pass ^ m_erase) bus_rdata = 16'h5A01;
                  else                bus_rdata = 16'hA5FE;
               end
               bus_ack = 1'b1;
            end
         end

         if (done || fail || rej) begin
            chk($countones({done, fail, rej}) == 1, "R12", "result pulses at once",
                {done, fail, rej}, 0);
            if (res_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected result pulse", {done, fail, rej}, 0);
            end else begin
               res_t r;
               r = res_q.pop_front();
               chk({done, fail, rej} == r.r, r.rq, "result {done,fail,rej}",
                   {done, fail, rej}, r.r);
            end
         end
      end
   end

   task automatic run_op(input bit er, input logic [SECT_W-1:0] s, input bit pre,
                         input int nfail, input bit poke, input string rq);
      int att;
      res_t r;
      m_erase = er;
      m_fails = nfail;
      m_reads = 0;
      r.rq = rq;
      if (er && !pre) begin
         r.r = 3'b001;
      end else begin
         att = (nfail + 1 < TRIES) ? nfail + 1 : TRIES;
         for (int i = 0; i < att; i++) push_attempt(er, s);
         r.r = (nfail < TRIES) ? 3'b100 : 3'b010;
      end
      res_q.push_back(r);
      @(negedge clk);
      req_valid = 1'b1; req_erase = er; req_sector = s; req_preprog = pre;
      @(negedge clk);
      req_valid = 1'b0; req_erase = 1'b0; req_preprog = 1'b0;
      if (poke) begin
         repeat (20) @(negedge clk);
         chk(busy == 1'b1, "R10", "busy during sequence", busy, 1);
         req_valid = 1'b1; req_erase = 1'b1; req_preprog = 1'b0; req_sector = ~s;
         @(negedge clk);
         req_valid = 1'b1; req_erase = 1'b0; req_preprog = 1'b0;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (res_q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(exp_q.size() == 0, rq, "bus cycles left unissued", exp_q.size(), 0);
      chk(busy == 1'b0 && bus_req == 1'b0, rq, "idle after result",
          {busy, bus_req}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      chk({bus_req, busy, done, fail, rej} == 5'b0, "R1", "outputs in reset",
          {bus_req, busy, done, fail, rej}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({bus_req, busy, done, fail, rej} == 5'b0, "R1", "outputs after reset",
          {bus_req, busy, done, fail, rej}, 0);

      run_op(1'b0, 10'h2A5, 1'b0, 0,  1'b0, "R6");  // set, first try
      run_op(1'b1, 10'h3FF, 1'b1, 0,  1'b0, "R6");  // clear, first try
      run_op(1'b0, 10'h001, 1'b0, 1,  1'b0, "R7");  // set, one retry
      run_op(1'b1, 10'h155, 1'b1, 2,  1'b0, "R7");  // clear, passes on last try
      run_op(1'b0, 10'h0F0, 1'b0, 99, 1'b0, "R8");  // set never verifies
      run_op(1'b1, 10'h0AA, 1'b1, 99, 1'b0, "R8");  // clear never verifies
      run_op(1'b1, 10'h123, 1'b0, 0,  1'b0, "R9");  // clear without confirmation
      run_op(1'b0, 10'h200, 1'b0, 0,  1'b1, "R10"); // requests while busy

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish (R1 to R12), actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule